// File: doc/BRIEF.md
# Transmit FCS Append Controller

This block sits in the byte-wide transmit path of a 10 Mb/s Ethernet MAC. Frame bytes arrive on a ready/valid input with start and end markers and leave on a ready/valid output. For each frame it decides whether a CRC-32 frame check sequence is added. When the answer is yes, it computes the CRC over the bytes passing through. It then emits the four check bytes straight after the last data byte and moves the end marker onto the final check byte.

The decision follows a fixed priority among three controls. An auto-pad enable forces the FCS. Failing that, a cleared global disable gives the FCS to every frame. Failing both, a per-frame add request enables it for that one frame. All three are sampled on the start-of-frame beat only. The block reports the rule it applied to each frame one cycle after that beat.

Top module: `tx_fcs_append`

## Requirements
- R1: After reset, and immediately while reset is asserted, m_valid and dec_valid are 0 and dec_code is 0. A reset applied while check bytes are being emitted drops them, and the next frame is handled normally.
- R2: With cfg_auto_pad = 0 and cfg_fcs_dis = 0 at the start beat, four FCS bytes are appended and dec_code reports 1.
- R3: With cfg_auto_pad = 1 at the start beat, four FCS bytes are appended whatever cfg_fcs_dis and s_add_fcs hold, and dec_code reports 3.
- R4: With cfg_fcs_dis = 1 and cfg_auto_pad = 0, s_add_fcs = 1 on the start beat appends the FCS with dec_code 2. s_add_fcs = 0 on the start beat passes the frame unchanged, with m_eof on its last data byte and dec_code 0.
- R5: s_add_fcs is taken only from the start beat. Its value on later beats of the same frame has no effect on the output bytes.
- R6: Changes to cfg_fcs_dis or cfg_auto_pad after the start beat do not alter the current frame. They govern the next frame.
- R7: The CRC uses polynomial 0x04C11DB7 and is preset to all ones. Each data byte is fed bit 7 first. The final value is inverted and sent bits 31:24 first, so the frame of ASCII "123456789" gets the bytes FC 89 19 18.
- R8: With m_ready held high, the first check byte follows the last data byte in the next cycle and the four check bytes are consecutive. Only the fourth check byte carries m_eof. s_ready stays 0 while check bytes are pending.
- R9: While m_ready is 0, s_ready is 0, and a pending check byte holds m_data and m_eof steady. Frames under backpressure come out byte-exact.
- R10: dec_valid pulses for one cycle, in the cycle after each accepted start beat, and dec_code then holds the code for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fcs_dis | input | 1 | Global FCS disable, sampled at the start beat |
| cfg_auto_pad | input | 1 | Auto-pad enable, forces FCS, sampled at the start beat |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted this cycle when high with s_valid |
| s_data | input | 8 | Input byte |
| s_sof | input | 1 | Input byte is the first of a frame |
| s_eof | input | 1 | Input byte is the last of a frame |
| s_add_fcs | input | 1 | Per-frame FCS request, used on the start beat |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the output byte |
| m_data | output | 8 | Output byte |
| m_sof | output | 1 | Output byte is the first of a frame |
| m_eof | output | 1 | Output byte is the last of a frame |
| dec_valid | output | 1 | One-cycle pulse carrying the per-frame decision |
| dec_code | output | 2 | 0 none, 1 global, 2 per-frame request, 3 auto-pad |

## Verification
The bench builds the block with the default polynomial 0x04C11DB7 and the all-ones preset. Its own CRC model can therefore be checked against the published "123456789" check value, and every priority path of the decision is reachable with these defaults. Frames of one to nine bytes cover the case where start and end fall on one beat. An alternating m_ready reaches the hold behaviour of both pass-through and check bytes.

// File: rtl/tx_fcs_append.sv
module tx_fcs_append #(
  parameter logic [31:0] POLY     = 32'h04C1_1DB7,
  parameter logic [31:0] CRC_INIT = 32'hFFFF_FFFF,
  parameter int          DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_fcs_dis,
  input  logic          cfg_auto_pad,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          s_sof,
  input  logic          s_eof,
  input  logic          s_add_fcs,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic          m_sof,
  output logic          m_eof,
  output logic          dec_valid,
  output logic [1:0]    dec_code
);
  localparam int CRC_W  = 32;
  localparam int NBYTES = CRC_W / DW;
  localparam int CNT_W  = $clog2(NBYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic [DW-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return r;
  endfunction

  logic             in_fcs;
  logic [CNT_W-1:0] cnt;
  logic [CRC_W-1:0] crc_q, fcs_q;
  logic             app_q;
  logic [1:0]       code_q;
  logic             dec_q;

  wire              s_fire   = s_valid && s_ready;
  wire [1:0]        code_now = cfg_auto_pad ? 2'd3 : !cfg_fcs_dis ? 2'd1 : s_add_fcs ? 2'd2 : 2'd0;
  wire              app_now  = s_sof ? (code_now != 2'd0) : app_q;
  wire [CRC_W-1:0]  crc_nxt  = crc_step(s_sof ? CRC_INIT : crc_q, s_data);

  assign s_ready   = m_ready && !in_fcs;
  assign m_valid   = in_fcs || s_valid;
  assign m_data    = in_fcs ? fcs_q[CRC_W-1 -: DW] : s_data;
  assign m_sof     = !in_fcs && s_sof;
  assign m_eof     = in_fcs ? (cnt == LAST) : (s_eof && !app_now);
  assign dec_valid = dec_q;
  assign dec_code  = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_fcs <= 1'b0;
      cnt    <= '0;
      crc_q  <= CRC_INIT;
      fcs_q  <= '0;
      app_q  <= 1'b0;
      code_q <= 2'd0;
      dec_q  <= 1'b0;
    end else begin
      dec_q <= s_fire && s_sof;
      if (s_fire) begin
        crc_q <= crc_nxt;
        if (s_sof) begin
          app_q  <= code_now != 2'd0;
          code_q <= code_now;
        end
        if (s_eof && app_now) begin
          in_fcs <= 1'b1;
          cnt    <= '0;
          fcs_q  <= ~crc_nxt;
        end
      end
      if (in_fcs && m_ready) begin
        fcs_q <= fcs_q << DW;
        cnt   <= cnt + 1'b1;
        if (cnt == LAST) in_fcs <= 1'b0;
      end
    end
  end

  p_hold_fcs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fcs && !m_ready) |=> (in_fcs && $stable(m_data) && $stable(m_eof)));

  p_no_input_fcs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_fcs |-> !s_ready);

  p_gapless_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_fire && s_eof && app_now) |=> (m_valid && !m_sof));

  p_eof_leaves_fcs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_eof) |=> !in_fcs);

  p_autopad_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_fire && s_sof && cfg_auto_pad) |=> (dec_valid && dec_code == 2'd3));

  p_global_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_fire && s_sof && !cfg_auto_pad && !cfg_fcs_dis) |=> (dec_valid && dec_code == 2'd1));

  p_dec_after_sof_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(s_valid && s_ready && s_sof));
endmodule

// File: tb/tx_fcs_append_tb.sv
`timescale 1ns/100ps
module tx_fcs_append_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_fcs_dis = 1'b0, cfg_auto_pad = 1'b0;
  logic s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0, s_add_fcs = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic m_ready = 1'b1;
  logic s_ready, m_valid, m_sof, m_eof, dec_valid;
  logic [7:0] m_data;
  logic [1:0] dec_code;

  int checks = 0, fails = 0;
  bit stall_on = 1'b0;

  always #2.5 clk = ~clk;

  tx_fcs_append u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fcs_dis(cfg_fcs_dis), .cfg_auto_pad(cfg_auto_pad),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof),
    .s_add_fcs(s_add_fcs), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_sof(m_sof), .m_eof(m_eof), .dec_valid(dec_valid), .dec_code(dec_code)
  );

  always @(negedge clk) m_ready <= stall_on ? ~m_ready : 1'b1;

  logic [7:0] o_data [0:1023];
  bit         o_sof  [0:1023];
  bit         o_eof  [0:1023];
  int         o_cyc  [0:1023];
  logic [1:0] d_code [0:255];
  int         d_cyc  [0:255];
  int ocount = 0, dcount = 0, cyc = 0;

  initial forever begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      cyc++;
      if (m_valid && m_ready && ocount < 1024) begin
        o_data[ocount] = m_data; o_sof[ocount] = m_sof; o_eof[ocount] = m_eof;
        o_cyc[ocount] = cyc; ocount++;
      end
      if (dec_valid && dcount < 256) begin
        d_code[dcount] = dec_code; d_cyc[dcount] = cyc; dcount++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      if (r[31] != d[b]) r = (r << 1) ^ 32'h04C1_1DB7;
      else               r = r << 1;
    end
    return r;
  endfunction

  // len[15:8] dis[7] ap[6] add_sof[5] add_rest[4] stall[3] flip[2] code[1:0]
  localparam logic [15:0] VEC [0:10] = '{
    16'h0601, 16'h0580, 16'h04B2, 16'h03C3, 16'h0790, 16'h05A2,
    16'h0101, 16'h08BA, 16'h0484, 16'h0343, 16'h0609
  };

  logic [7:0] exp_b [0:63];
  logic [7:0] dat_b [0:63];

  task automatic send_and_check(input int len, input bit dis, input bit ap, input bit add_sof,
                                input bit add_rest, input bit stall, input bit flip,
                                input logic [1:0] code, input string req);
    int os = ocount, ds = dcount, n;
    bit app = code != 2'd0;
    logic [31:0] crc = 32'hFFFF_FFFF;
    bit ok;
    for (int i = 0; i < len; i++) begin
      exp_b[i] = dat_b[i];
      crc = ref_crc(crc, dat_b[i]);
    end
    crc = ~crc;
    for (int k = 0; k < 4; k++) exp_b[len+k] = crc[31-8*k -: 8];
    n = len + (app ? 4 : 0);
    @(negedge clk);
    cfg_fcs_dis = dis; cfg_auto_pad = ap; stall_on = stall;
    for (int i = 0; i < len; i++) begin
      s_valid = 1'b1; s_data = dat_b[i]; s_sof = (i == 0); s_eof = (i == len - 1);
      s_add_fcs = (i == 0) ? add_sof : add_rest;
      #2;
      while (!s_ready) begin @(negedge clk); #2; end
      @(negedge clk);
      if (i == 0 && flip) begin cfg_fcs_dis = ~dis; cfg_auto_pad = 1'b1; end
    end
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0; s_add_fcs = 1'b0;
    repeat (40) @(negedge clk);
    stall_on = 1'b0;
    repeat (2) @(negedge clk);
    check(ocount - os == n, req, "output byte count", ocount - os, n);
    ok = 1'b1;
    for (int k = 0; k < n && os + k < ocount; k++) if (o_data[os+k] !== exp_b[k]) ok = 1'b0;
    check(ok, req, "frame bytes incl. FCS (R7)", o_data[ocount-1], exp_b[n-1]);
    ok = 1'b1;
    for (int k = 0; k < ocount - os; k++)
      if (o_eof[os+k] != (k == n - 1) || o_sof[os+k] != (k == 0)) ok = 1'b0;
    check(ok, req, "start/end markers (R8)", o_eof[ocount-1], 1);
    if (!stall) begin
      ok = 1'b1;
      for (int k = 1; k < ocount - os; k++) if (o_cyc[os+k] != o_cyc[os] + k) ok = 1'b0;
      check(ok, req, "back-to-back transfers (R8)", o_cyc[ocount-1] - o_cyc[os], n - 1);
    end
    check(dcount - ds == 1 && d_code[ds] == code, req, "decision code", d_code[ds], code);
    check(d_cyc[ds] == o_cyc[os] + 1, "R10", "decision pulse cycle", d_cyc[ds], o_cyc[os] + 1);
  endtask

  task automatic run_all();
    int os;
    repeat (3) @(negedge clk);
    #2;
    check(m_valid == 0 && dec_valid == 0 && dec_code == 0, "R1", "reset state", {m_valid, dec_valid, dec_code}, 0);
    @(negedge clk); rst_n = 1'b1;
    #2;
    check(s_ready == 1 && m_valid == 0, "R1", "ready after reset", {s_ready, m_valid}, 2);

    for (int v = 0; v < 11; v++) begin
      logic [15:0] e = VEC[v];
      string req;
      for (int i = 0; i < e[15:8]; i++) dat_b[i] = 8'((v * 37) + (i * 13) + 5);
      if (e[2]) req = "R6";
      else if (e[3]) req = "R9";
      else if (e[5] != e[4]) req = "R5";
      else if (e[1:0] == 2'd3) req = "R3";
      else if (e[1:0] == 2'd1) req = "R2";
      else req = "R4";
      send_and_check(int'(e[15:8]), e[7], e[6], e[5], e[4], e[3], e[2], e[1:0], req);
    end

    // Known check value for "123456789"
    for (int i = 0; i < 9; i++) dat_b[i] = 8'h31 + 8'(i);
    os = ocount;
    send_and_check(9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, "R7");
    check({o_data[os+9], o_data[os+10], o_data[os+11], o_data[os+12]} == 32'hFC89_1918,
          "R7", "known check value", {o_data[os+9], o_data[os+10], o_data[os+11], o_data[os+12]}, 32'hFC89_1918);

    // Reset while check bytes are pending
    @(negedge clk);
    cfg_fcs_dis = 1'b0; cfg_auto_pad = 1'b0;
    s_valid = 1'b1; s_data = 8'hA5; s_sof = 1'b1; s_eof = 1'b1; s_add_fcs = 1'b0;
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
    #1;
    check(m_valid == 1 && s_ready == 0, "R8", "input blocked during FCS", {m_valid, s_ready}, 2);
    rst_n = 1'b0;
    #1;
    check(m_valid == 0 && dec_valid == 0 && dec_code == 0, "R1", "reset mid-FCS", {m_valid, dec_valid, dec_code}, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) dat_b[i] = 8'h10 + 8'(i);
    send_and_check(3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, "R1");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule